// File: doc/BRIEF.md
# UART Register Front-End

This block is the processor-side face of a UART. Software sees two byte-wide locations: a data location and a status location. Writing the data location fills a one-byte transmit holding register. Reading it removes the oldest byte from a two-entry receive queue. The status location shows the receive, transmit and empty flags and the per-byte receive error bits. It also holds two plain mode bits that are passed out to the line logic.

On the transmit side the block offers the held byte to an external shift engine. It does this whenever the transmitter is enabled and the engine reports that it is free. The engine signals the end of each frame with a one-cycle pulse.

On the receive side an external deserializer delivers each byte with its frame-error and parity-error markers. The block queues the byte and the markers together and marks overruns. Three interrupt request outputs are formed from the flags and per-flag enable inputs.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status location reads 0x20: only the empty flag (bit 5) is set. All interrupt outputs and `tx_load` are low.
- R2: A data write (address 0) while the empty flag is 1 captures the byte and clears the empty flag. A data write while the empty flag is 0 is discarded, and the byte already held is the one later handed to the shifter.
- R3: While `tx_en` is 1, a byte is held and `sh_ready` is 1, `tx_load` is high and `tx_data` carries the held byte. At that clock edge the holding register is freed, so the empty flag is 1 afterwards. Bytes reach the shifter in write order.
- R4: A data read (address 0) returns the oldest queued byte and removes it. The two-entry queue keeps arrival order. A data read of an empty queue returns 0x00 and changes nothing.
- R5: Status bit 7 (receive complete) is 1 exactly while the queue holds at least one byte.
- R6: A byte that arrives while both entries are full, with no read in the same cycle, is dropped. The overrun bit is set on the newest stored entry. Status bit 3 shows the overrun bit of the oldest entry.
- R7: The frame-error and parity-error inputs are stored with each byte. Status bit 4 shows the frame error and bit 2 the parity error of the oldest entry. All three error bits read 0 when the queue is empty.
- R8: While `rx_en` is 0 the queue is emptied and incoming bytes are ignored. After re-enabling, the status shows receive complete 0.
- R9: Status bit 6 (transmit complete) is set by a `tx_done` pulse only when the holding register is empty in that cycle. If a byte is waiting, the pulse leaves the bit unchanged.
- R10: The transmit-complete bit is cleared by a `txc_ack` pulse or by a status write (address 1) with bit 6 = 1. A status write with bit 6 = 0 leaves it unchanged.
- R11: `irq_rxc`, `irq_txc` and `irq_dre` each equal their flag ANDed with the enable inputs `ie_rxc`, `ie_txc` and `ie_dre` respectively.
- R12: `char_len` selects the character size: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Received bytes store zeros above the character size, and `tx_data` shows zeros there.
- R13: Status bits 1 and 0 are read/write mode bits, driven out on `dbl_speed` and `mp_mode`. Status bits 7..2 ignore written values, apart from the clear described in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = data location, 1 = status location |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the queue at the data location) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| char_len | input | 2 | Character size select |
| ie_rxc | input | 1 | Receive-complete interrupt enable |
| ie_txc | input | 1 | Transmit-complete interrupt enable |
| ie_dre | input | 1 | Empty-flag interrupt enable |
| sh_ready | input | 1 | Shift engine can accept a byte |
| tx_done | input | 1 | Shift engine finished a frame (pulse) |
| txc_ack | input | 1 | Transmit-complete interrupt serviced (pulse) |
| tx_load | output | 1 | Hands `tx_data` to the shift engine this cycle |
| tx_data | output | 8 | Held byte, masked to the character size |
| rx_valid | input | 1 | Deserializer delivers a byte (pulse) |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Frame error for the delivered byte |
| rx_perr | input | 1 | Parity error for the delivered byte |
| irq_rxc | output | 1 | Receive-complete interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Empty-flag interrupt request |
| dbl_speed | output | 1 | Mode bit from status bit 1 |
| mp_mode | output | 1 | Mode bit from status bit 0 |

## Verification
A corrupted queue count shows up on the very next status read: bit 7 is wrong, a read returns a stale byte, or an overrun lands on the wrong entry. The error pattern check therefore reads status before and after each pop. A stuck empty flag shows within one byte: either a second write overwrites the pending byte, or a write never reaches `tx_load`. The scoreboard catches both, because the transmitted stream differs from the accepted writes. A wrong transmit-complete update shows on the first status read after a frame ends. The test deliberately reads it while a second byte is still pending.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic [1:0]    char_len,
  input  logic          ie_rxc,
  input  logic          ie_txc,
  input  logic          ie_dre,
  input  logic          sh_ready,
  input  logic          tx_done,
  input  logic          txc_ack,
  output logic          tx_load,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_ferr,
  input  logic          rx_perr,
  output logic          irq_rxc,
  output logic          irq_txc,
  output logic          irq_dre,
  output logic          dbl_speed,
  output logic          mp_mode
);
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam logic [1:0] FULL = 2'd2;

  logic [DW-1:0] hold, d0, d1;
  logic          dre, txc, u2x, mpcm;
  logic [1:0]    cnt;
  logic          fe0, fe1, pe0, pe1, or0, or1;

  wire [DW-1:0] mask   = {DW{1'b1}} >> ({{(DW-2){1'b0}}, 2'd3 - char_len} + DW - 8);
  wire          wr_dat = bus_wr & (bus_addr == ADDR_DATA);
  wire          wr_st  = bus_wr & (bus_addr == ADDR_STAT);
  wire          rxc    = (cnt != 2'd0);
  wire          pop    = bus_rd & (bus_addr == ADDR_DATA) & rxc;
  wire          rx_in  = rx_en & rx_valid;
  wire          push   = rx_in & ((cnt != FULL) | pop);
  wire          ovr    = rx_in & (cnt == FULL) & ~pop;
  wire [DW-1:0] rx_m   = rx_data & mask;
  wire [7:0]    status = {rxc, txc, dre, fe0 & rxc, or0 & rxc, pe0 & rxc, u2x, mpcm};

  assign tx_load   = tx_en & ~dre & sh_ready;
  assign tx_data   = hold & mask;
  assign bus_rdata = (bus_addr == ADDR_STAT) ? DW'(status) : (rxc ? d0 : '0);
  assign irq_rxc   = rxc & ie_rxc;
  assign irq_txc   = txc & ie_txc;
  assign irq_dre   = dre & ie_dre;
  assign dbl_speed = u2x;
  assign mp_mode   = mpcm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      dre  <= 1'b1;
      txc  <= 1'b0;
      u2x  <= 1'b0;
      mpcm <= 1'b0;
    end else begin
      if (wr_dat && dre) begin
        hold <= bus_wdata;
        dre  <= 1'b0;
      end else if (tx_load) begin
        dre  <= 1'b1;
      end
      if (tx_done && dre)                    txc <= 1'b1;
      else if (txc_ack || (wr_st && bus_wdata[6])) txc <= 1'b0;
      if (wr_st) begin
        u2x  <= bus_wdata[1];
        mpcm <= bus_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      cnt <= 2'd0;
      d0  <= '0;  d1  <= '0;
      fe0 <= 1'b0; fe1 <= 1'b0;
      pe0 <= 1'b0; pe1 <= 1'b0;
      or0 <= 1'b0; or1 <= 1'b0;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) begin
            d0 <= rx_m; fe0 <= rx_ferr; pe0 <= rx_perr; or0 <= 1'b0;
          end else begin
            d1 <= rx_m; fe1 <= rx_ferr; pe1 <= rx_perr; or1 <= 1'b0;
          end
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          d0 <= d1; fe0 <= fe1; pe0 <= pe1; or0 <= or1;
          or1 <= 1'b0;
          cnt <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) begin
            d0 <= rx_m; fe0 <= rx_ferr; pe0 <= rx_perr; or0 <= 1'b0;
          end else begin
            d0 <= d1; fe0 <= fe1; pe0 <= pe1; or0 <= or1;
            d1 <= rx_m; fe1 <= rx_ferr; pe1 <= rx_perr; or1 <= 1'b0;
          end
        end
        default: ;
      endcase
      if (ovr) or1 <= 1'b1;
    end
  end

  // R2: a write while the holding register is busy leaves it unchanged
  a_r2_drop_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !dre) |=> $stable(hold));
  // R3: a handoff frees the holding register
  a_r3_load_frees: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> dre);
  // R6: the queue never holds more than two entries
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R8: a disabled receiver leaves an empty queue
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rxc);
  // R9: frame end with nothing waiting raises transmit complete
  a_r9_txc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && dre) |=> txc);
  // R10: acknowledge without a new frame end clears transmit complete
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_ack && !tx_done) |=> !txc);
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_addr = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, tx_data, rx_data = 0;
  logic tx_en = 1, rx_en = 1, ie_rxc = 0, ie_txc = 0, ie_dre = 0;
  logic [1:0] char_len = 2'd3;
  logic sh_ready = 1, tx_done = 0, txc_ack = 0, tx_load;
  logic rx_valid = 0, rx_ferr = 0, rx_perr = 0;
  logic irq_rxc, irq_txc, irq_dre, dbl_speed, mp_mode;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] v;
  logic done_flag = 0;

  always #5 clk = ~clk;

  uart_regfront dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic bwr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic brd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic txw(input logic [7:0] d, input logic accept);
    if (accept) exp_q.push_back(d & (8'hFF >> (2'd3 - char_len)));
    bwr(1'b0, d);
  endtask

  task automatic rxs(input logic [7:0] d, input logic fe, input logic pe);
    @(negedge clk); rx_data = d; rx_ferr = fe; rx_perr = pe; rx_valid = 1;
    @(negedge clk); rx_valid = 0; rx_ferr = 0; rx_perr = 0;
  endtask

  // shift-engine model and transmit scoreboard monitor
  initial begin
    int busy = 0;
    logic drop = 0;
    forever begin
      @(negedge clk);
      tx_done = 0;
      if (drop) begin sh_ready = 0; drop = 0; end
      else if (busy > 0) begin
        busy--;
        if (busy == 0) begin tx_done = 1; sh_ready = 1; end
      end
      #2;
      if (tx_load) begin
        if (exp_q.size() == 0) chk("R2 unexpected handoff", tx_data, 8'hxx);
        else chk("R3 handoff byte", tx_data, exp_q.pop_front());
        drop = 1; busy = 8;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    brd(1'b1, v); chk("R1 reset status", v, 8'h20);
    chk("R1 irqs/load", {5'b0, irq_rxc, irq_txc, tx_load}, 8'h00);
    // R3 / R9
    txw(8'hA5, 1); repeat (14) @(negedge clk);
    brd(1'b1, v); chk("R9 txc after frame", v, 8'h60);
    // R10
    bwr(1'b1, 8'h00); brd(1'b1, v); chk("R10 write zero keeps txc", v, 8'h60);
    bwr(1'b1, 8'h40); brd(1'b1, v); chk("R10 write one clears txc", v, 8'h20);
    // R2
    tx_en = 0; txw(8'h11, 1);
    brd(1'b1, v); chk("R2 empty flag cleared", v & 8'h20, 8'h00);
    txw(8'h22, 0);
    @(negedge clk); tx_en = 1; repeat (14) @(negedge clk);
    chk("R2 dropped write not sent", 8'(exp_q.size()), 8'h00);
    // R11 / R10 acknowledge
    ie_txc = 1; #1 chk("R11 irq_txc", {7'b0, irq_txc}, 8'h01);
    @(negedge clk); txc_ack = 1; @(negedge clk); txc_ack = 0; #1;
    chk("R10 ack clears irq_txc", {7'b0, irq_txc}, 8'h00);
    ie_txc = 0;
    // R9 with a byte waiting
    txw(8'h5A, 1); repeat (2) @(negedge clk); txw(8'h3B, 1);
    repeat (8) @(negedge clk);
    brd(1'b1, v); chk("R9 no txc while byte waiting", v & 8'h40, 8'h00);
    repeat (16) @(negedge clk);
    brd(1'b1, v); chk("R9 txc after last frame", v & 8'h40, 8'h40);
    // R12 transmit masking
    char_len = 2'd0; txw(8'hFF, 1); repeat (14) @(negedge clk);
    char_len = 2'd3; bwr(1'b1, 8'h40);
    // R4 / R5
    rxs(8'h3C, 0, 0); rxs(8'hC3, 0, 0);
    brd(1'b1, v); chk("R5 rxc with data", v, 8'hA0);
    brd(1'b0, v); chk("R4 first byte", v, 8'h3C);
    brd(1'b0, v); chk("R4 second byte", v, 8'hC3);
    brd(1'b1, v); chk("R5 rxc cleared", v, 8'h20);
    brd(1'b0, v); chk("R4 empty read", v, 8'h00);
    // R6 / R7
    rxs(8'hA1, 1, 0); rxs(8'hB2, 0, 0); rxs(8'hC4, 0, 0);
    brd(1'b1, v); chk("R7 frame error of head", v, 8'hB0);
    brd(1'b0, v); chk("R6 head byte", v, 8'hA1);
    brd(1'b1, v); chk("R6 overrun on newest", v, 8'hA8);
    brd(1'b0, v); chk("R6 second byte", v, 8'hB2);
    brd(1'b0, v); chk("R6 lost byte absent", v, 8'h00);
    rxs(8'h44, 0, 1);
    brd(1'b1, v); chk("R7 parity error of head", v, 8'hA4);
    ie_rxc = 1; #1 chk("R11 irq_rxc", {7'b0, irq_rxc}, 8'h01);
    brd(1'b0, v); chk("R4 parity byte", v, 8'h44);
    #1 chk("R11 irq_rxc low", {7'b0, irq_rxc}, 8'h00);
    ie_rxc = 0;
    // R12 receive masking
    char_len = 2'd1; rxs(8'hFF, 0, 0);
    brd(1'b0, v); chk("R12 six-bit receive", v, 8'h3F);
    char_len = 2'd3;
    // R8
    rxs(8'h12, 0, 0); rxs(8'h34, 0, 0);
    @(negedge clk); rx_en = 0;
    rxs(8'h77, 0, 0);
    @(negedge clk); rx_en = 1;
    brd(1'b1, v); chk("R8 flushed status", v, 8'h20);
    brd(1'b0, v); chk("R8 flushed data", v, 8'h00);
    // R11 empty-flag interrupt
    ie_dre = 1; #1 chk("R11 irq_dre", {7'b0, irq_dre}, 8'h01);
    ie_dre = 0; #1 chk("R11 irq_dre off", {7'b0, irq_dre}, 8'h00);
    // R13
    bwr(1'b1, 8'hBF); brd(1'b1, v); chk("R13 mode bits", v, 8'h23);
    chk("R13 mode pins", {6'b0, dbl_speed, mp_mode}, 8'h03);
    chk("R3 all bytes sent", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule